// File: doc/BRIEF.md
# Node Fault Status Tracker

Each network node carries one tracker that keeps two small fault registers. The local register records the fault state of the node's own four links, its processing element and its router, as reported by detector inputs. The regional register records which of the four adjacent nodes is unhealthy. It learns this over one-bit wires that connect it to the trackers in those nodes.

Each tracker sends a single summary bit to all four neighbours. The bit is high while any bit of its local register is set. A neighbour that receives a high summary bit marks the regional bit for the direction it came from. The tracker merges the regional bits with its own local link faults into an avoid mask. It qualifies the productive directions that the router asks about, such as east and south for a destination to the lower right. If every productive direction is blocked, it raises a no-route flag and offers no direction.

Top module: `node_fault_tracker`

## Requirements
- R1: While rst_ni is low, all registers clear and the outputs lfr_o, rfr_o, nbr_flt_o and avoid_mask_o are all zero.
- R2: On each clock the local register loads fault_det_i. Bit positions are: 0 north link, 1 east link, 2 south link, 3 west link, 4 processing element, 5 router. The value appears on lfr_o one clock after it is driven.
- R3: One clock after the local register changes, every bit of nbr_flt_o equals the OR of all six local register bits. The same value goes out on all four directions.
- R4: Regional bit d (0 north, 1 east, 2 south, 3 west) follows nbr_flt_i[d] SYNC_STAGES clocks later, both when it sets and when it clears.
- R5: avoid_mask_o[d] is high when regional bit d is set or when local link bit d is set, even if that neighbour reports healthy. The processing-element and router bits never set a mask bit.
- R6: ok_dir_o equals dst_dir_i with the masked directions removed. For example, with dst_dir_i = east|south and the east neighbour faulty, only south remains.
- R7: When dst_dir_i is nonzero and every requested direction is masked, no_route_o is 1 and ok_dir_o is 0.
- R8: When dst_dir_i is zero, no_route_o stays 0 whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_det_i | input | 6 | Local fault detector levels |
| nbr_flt_i | input | 4 | Summary bits from the N/E/S/W neighbours |
| dst_dir_i | input | 4 | Productive directions toward the destination |
| nbr_flt_o | output | 4 | Own summary bit, one copy per direction |
| lfr_o | output | 6 | Local fault register |
| rfr_o | output | 4 | Regional fault register |
| avoid_mask_o | output | 4 | Directions to avoid |
| ok_dir_o | output | 4 | Requested directions still usable |
| no_route_o | output | 1 | All requested directions are masked |

## Verification
The bench builds the tracker with SYNC_STAGES = 2 rather than the default of 1. This puts a neighbour report, still in flight through the synchroniser, between its arrival and its effect on the regional register. It can then tell a correct delay from one stage short or one stage long. The bench also runs a neighbour that clears its fault and checks that the regional bit releases after the same delay. It forces a local link fault against a healthy neighbour, and it covers the case where a processing-element fault must raise the summary bit but leave the mask unchanged.

// File: rtl/nft_pkg.sv
package nft_pkg;
  localparam int NUM_DIR = 4;
  localparam int LOC_W   = NUM_DIR + 2;
  localparam int LOC_PE  = NUM_DIR;
  localparam int LOC_RTR = NUM_DIR + 1;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;
endpackage

// File: rtl/nft_local_reg.sv
module nft_local_reg #(
  parameter int LW = nft_pkg::LOC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] det_i,
  output logic [LW-1:0] lfr_o,
  output logic          summary_o
);
  logic [LW-1:0] lfr_q;
  logic          sum_q;
  logic          live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfr_q  <= '0;
      sum_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      lfr_q  <= det_i;
      sum_q  <= |lfr_q;
      live_q <= 1'b1;
    end
  end

  assign lfr_o     = lfr_q;
  assign summary_o = sum_q;

  assert_lfr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> lfr_o == $past(det_i));
  assert_summary_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> summary_o == $past(|lfr_o));
endmodule

// File: rtl/nft_region_sync.sv
module nft_region_sync #(
  parameter int ND          = nft_pkg::NUM_DIR,
  parameter int SYNC_STAGES = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [ND-1:0] nbr_i,
  output logic [ND-1:0] rfr_o
);
  logic [ND-1:0] stg_q [SYNC_STAGES];
  logic          live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= nbr_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign rfr_o = stg_q[SYNC_STAGES-1];

  // first stage samples the neighbour wires each clock (R4)
  assert_sync_in_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> stg_q[0] == $past(nbr_i));
endmodule

// File: rtl/nft_avoid.sv
module nft_avoid #(
  parameter int ND = nft_pkg::NUM_DIR
) (
  input  logic [ND-1:0] rfr_i,
  input  logic [ND-1:0] link_i,
  input  logic [ND-1:0] dst_i,
  output logic [ND-1:0] mask_o,
  output logic [ND-1:0] ok_o,
  output logic          no_route_o
);
  always_comb begin
    mask_o     = rfr_i | link_i;
    ok_o       = dst_i & ~mask_o;
    no_route_o = (dst_i != '0) && (ok_o == '0);
  end
endmodule

// File: rtl/node_fault_tracker.sv
module node_fault_tracker #(
  parameter int SYNC_STAGES = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [nft_pkg::LOC_W-1:0] fault_det_i,
  input  logic [nft_pkg::NUM_DIR-1:0] nbr_flt_i,
  input  logic [nft_pkg::NUM_DIR-1:0] dst_dir_i,
  output logic [nft_pkg::NUM_DIR-1:0] nbr_flt_o,
  output logic [nft_pkg::LOC_W-1:0] lfr_o,
  output logic [nft_pkg::NUM_DIR-1:0] rfr_o,
  output logic [nft_pkg::NUM_DIR-1:0] avoid_mask_o,
  output logic [nft_pkg::NUM_DIR-1:0] ok_dir_o,
  output logic                      no_route_o
);
  import nft_pkg::*;

  logic summary;

  nft_local_reg #(.LW(LOC_W)) u_local (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .det_i     (fault_det_i),
    .lfr_o     (lfr_o),
    .summary_o (summary)
  );

  nft_region_sync #(.ND(NUM_DIR), .SYNC_STAGES(SYNC_STAGES)) u_region (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nbr_i  (nbr_flt_i),
    .rfr_o  (rfr_o)
  );

  nft_avoid #(.ND(NUM_DIR)) u_avoid (
    .rfr_i      (rfr_o),
    .link_i     (lfr_o[NUM_DIR-1:0]),
    .dst_i      (dst_dir_i),
    .mask_o     (avoid_mask_o),
    .ok_o       (ok_dir_o),
    .no_route_o (no_route_o)
  );

  assign nbr_flt_o = {NUM_DIR{summary}};

  // a faulty own link or a faulty neighbour never yields a usable direction
  assert_link_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lfr_o[NUM_DIR-1:0] | rfr_o) & ok_dir_o) == '0);
  assert_no_route_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_route_o |-> (ok_dir_o == '0 && dst_dir_i != '0));
  assert_idle_dst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_dir_i == '0 |-> !no_route_o);
endmodule

// File: tb/sim_node_fault_tracker.sv
`timescale 1ns/1ps
module sim_node_fault_tracker;
  localparam int SYNC = 2;
  localparam logic [3:0] N = 4'b0001, E = 4'b0010, S = 4'b0100, W = 4'b1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] fault_det = '0;
  logic [3:0] nbr_in = '0, dst = '0;
  logic [3:0] nbr_out, rfr, mask, ok;
  logic [5:0] lfr;
  logic       no_route;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  node_fault_tracker #(.SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fault_det_i(fault_det), .nbr_flt_i(nbr_in),
    .dst_dir_i(dst), .nbr_flt_o(nbr_out), .lfr_o(lfr), .rfr_o(rfr),
    .avoid_mask_o(mask), .ok_dir_o(ok), .no_route_o(no_route));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    fault_det = 6'h3f; nbr_in = 4'hf; dst = 4'hf;
    cyc(3);
    check("R1 lfr", 8'(lfr), 8'h00);
    check("R1 rfr", 8'(rfr), 8'h00);
    check("R1 nbr_out", 8'(nbr_out), 8'h00);
    check("R1 mask", 8'(mask), 8'h00);
    fault_det = '0; nbr_in = '0; dst = '0;
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_local_pe;
    fault_det = 6'b010000;           // PE fault only
    dst = E | S;
    cyc(1);
    check("R2 lfr pe", 8'(lfr), 8'h10);
    check("R3 summary not yet", 8'(nbr_out), 8'h0);
    check("R5 pe no mask", 8'(mask), 8'h0);
    check("R6 ok with pe fault", 8'(ok), 8'(E | S));
    cyc(1);
    check("R3 summary all dirs", 8'(nbr_out), 8'hf);
    fault_det = '0;
    cyc(1);
    check("R3 summary held", 8'(nbr_out), 8'hf);
    cyc(1);
    check("R3 summary clear", 8'(nbr_out), 8'h0);
    fault_det = 6'b100000;           // router fault
    cyc(2);
    check("R3 router summary", 8'(nbr_out), 8'hf);
    check("R5 router no mask", 8'(mask), 8'h0);
    fault_det = '0;
    cyc(2);
  endtask

  task automatic t_link_force;
    nbr_in = '0;
    fault_det = 6'b000100;           // south link
    dst = S | W;
    cyc(1);
    check("R5 link forces mask", 8'(mask), 8'(S));
    check("R6 ok minus south", 8'(ok), 8'(W));
    check("R2 lfr link", 8'(lfr), 8'h04);
    fault_det = '0;
    cyc(1);
    check("R5 link released", 8'(mask), 8'h0);
  endtask

  task automatic t_region_delay;
    dst = E | S;
    nbr_in = E;
    cyc(SYNC - 1);
    check("R4 not yet set", 8'(rfr), 8'h0);
    cyc(1);
    check("R4 east set", 8'(rfr), 8'(E));
    check("R5 east masked", 8'(mask), 8'(E));
    check("R6 lower-right goes south", 8'(ok), 8'(S));
    check("R7 route exists", 8'(no_route), 8'h0);
    nbr_in = '0;
    cyc(SYNC - 1);
    check("R4 still set", 8'(rfr), 8'(E));
    cyc(1);
    check("R4 east cleared", 8'(rfr), 8'h0);
    check("R6 east back", 8'(ok), 8'(E | S));
  endtask

  task automatic t_no_route;
    dst = E | S;
    nbr_in = E;
    fault_det = 6'b000100;
    cyc(SYNC);
    check("R7 no route", 8'(no_route), 8'h1);
    check("R7 ok empty", 8'(ok), 8'h0);
    dst = '0;
    cyc(1);
    check("R8 idle dst", 8'(no_route), 8'h0);
    dst = N | W;
    cyc(1);
    check("R7 other dirs ok", 8'(ok), 8'(N | W));
    check("R7 no flag", 8'(no_route), 8'h0);
    nbr_in = 4'hf; fault_det = '0;
    cyc(SYNC);
    check("R4 all neighbours", 8'(rfr), 8'hf);
    check("R7 all masked", 8'(no_route), 8'h1);
    nbr_in = '0; dst = '0;
    cyc(SYNC + 2);
    check("R4 all clear", 8'(rfr), 8'h0);
  endtask

  initial begin
    cyc(1);
    t_reset;
    t_local_pe;
    t_link_force;
    t_region_delay;
    t_no_route;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule